// File: doc/BRIEF.md
# Per-pin GPIO interrupt controller

A register-mapped GPIO block for a configurable number of pins. Every pin owns a private 4 KiB address window containing three 32-bit registers: a data register (driven output plus synchronized input), an interrupt configuration register and an interrupt status register. Pin inputs pass through a two-stage synchronizer before any use. Each pin can detect an active level (high or low) or a rising, falling or any edge, and records the event in a sticky pending flag.

A single host interrupt line combines all pins whose pending flag is set, whose interrupt enable is on and whose route field selects the host. Software services a pin by reading its status and writing it back with bit 0 cleared. The bus is a plain single-cycle write strobe with combinational read data.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every data, configuration and status register reads zero, `pin_out` is all zero and `irq_out` is low.
- R2: The data register sits at offset 0x004 of a pin window; written bit 1 drives that pin's `pin_out` bit and reads back, and bit 0 reads the pin input, which appears two clock edges after the input changes.
- R3: The configuration register at offset 0x008 stores bits 7:0 as written and reads bits 31:8 as zero.
- R4: Configuration bits 3:2 pick the detect kind (0 level, 1 rising edge, 2 falling edge, 3 any edge); bit 1 only matters in level mode, where 1 means active-high and 0 active-low.
- R5: A detected event sets the pin's pending flag only while configuration bit 4 is 1; for an edge, the flag reads 1 three clock edges after the input changes and not before.
- R6: In level mode the flag is set again on every cycle the active level is present, so a clear write only sticks once the synchronized level is inactive.
- R7: The status register at offset 0x00C shows the pending flag in bit 0; writing it with bit 0 = 0 clears the flag, writing bit 0 = 1 leaves it unchanged.
- R8: `irq_out` is high exactly when some pin has its pending flag set, configuration bit 0 (enable) = 1 and configuration bits 7:5 equal to 3.
- R9: Rewriting only the enable bit masks or unmasks a pin's contribution to `irq_out` without losing its pending flag or other configuration fields.
- R10: A pin index at or above `NUM_PINS`, or any offset other than 0x004, 0x008 and 0x00C, reads zero and ignores writes.
- R11: The pin index is taken from address bits above bit 11 (a stride of 0x1000); an access to one pin never changes another pin's state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pin input levels, may be asynchronous |
| pin_out | output | NUM_PINS | Driven pin output values |
| irq_out | output | 1 | Host summary interrupt |

## Verification
The assertions take the bus inputs to be known and steady around each rising edge, while `pin_in` may change at any time because only its synchronized copy feeds the logic. The stimulus changes all inputs at the falling edge, so every write and every input toggle is seen by exactly one edge. Random writes hit valid and invalid pin indices and offsets alike, so the ignored-access rules are exercised alongside normal traffic.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                irq_out
);
  localparam int         IDX_W      = ADDR_W - 12;
  localparam logic [11:0] OFS_DATA  = 12'h004;
  localparam logic [11:0] OFS_CFG   = 12'h008;
  localparam logic [11:0] OFS_STAT  = 12'h00C;
  localparam logic [2:0]  ROUTE_HOST = 3'd3;

  logic [IDX_W-1:0]    acc_idx;
  logic [11:0]         acc_ofs;
  logic                idx_ok;
  logic [NUM_PINS-1:0] sync1, sync2, prev_q, out_q, pend_q, hit, irq_src;
  logic [7:0]          cfg_q [NUM_PINS];

  assign acc_idx = bus_addr[ADDR_W-1:12];
  assign acc_ofs = bus_addr[11:0];
  assign idx_ok  = 32'(acc_idx) < 32'(NUM_PINS);
  assign pin_out = out_q;
  assign irq_out = |irq_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev_q <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      prev_q <= sync2;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      case (cfg_q[i][3:2])
        2'd0:    hit[i] = cfg_q[i][1] ? sync2[i] : ~sync2[i];
        2'd1:    hit[i] = sync2[i] & ~prev_q[i];
        2'd2:    hit[i] = ~sync2[i] & prev_q[i];
        default: hit[i] = sync2[i] ^ prev_q[i];
      endcase
      irq_src[i] = pend_q[i] & cfg_q[i][0] & (cfg_q[i][7:5] == ROUTE_HOST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (bus_we && idx_ok && acc_idx == IDX_W'(i)) begin
          if (acc_ofs == OFS_DATA) out_q[i] <= bus_wdata[1];
          if (acc_ofs == OFS_CFG)  cfg_q[i] <= bus_wdata[7:0];
        end
        if (cfg_q[i][4] && hit[i])
          pend_q[i] <= 1'b1;
        else if (bus_we && idx_ok && acc_idx == IDX_W'(i) &&
                 acc_ofs == OFS_STAT && !bus_wdata[0])
          pend_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (idx_ok && acc_idx == IDX_W'(i)) begin
        case (acc_ofs)
          OFS_DATA: bus_rdata = {30'd0, out_q[i], sync2[i]};
          OFS_CFG:  bus_rdata = {24'd0, cfg_q[i]};
          OFS_STAT: bus_rdata = {31'd0, pend_q[i]};
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q != '0)); // R8
  AST_BAD_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> (bus_rdata == 32'd0)); // R10

  for (genvar g = 0; g < NUM_PINS; g++) begin : gen_chk
    AST_PEND_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(cfg_q[g][4])); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && idx_ok && acc_idx == IDX_W'(g) && acc_ofs == OFS_STAT &&
       !bus_wdata[0] && !(cfg_q[g][4] && hit[g])) |=> !pend_q[g]); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && idx_ok && acc_idx == IDX_W'(g) && acc_ofs == OFS_DATA)
      |=> $stable(out_q[g])); // R2
  end
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;
  localparam int NP = 8;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out;
  logic        irq_out;
  int nchk = 0, nerr = 0;
  bit done = 0;

  gpio_irq_ctrl u_gpio_irq_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq_out(irq_out));

  always #2 clk = ~clk;

  logic [NP-1:0][7:0] m_cfg;
  logic [NP-1:0] m_out, m_pend, m_s1, m_s2, m_prev;

  function automatic bit m_hit(int p);
    case (m_cfg[p][3:2])
      2'd0: return m_cfg[p][1] ? m_s2[p] : !m_s2[p];
      2'd1: return m_s2[p] && !m_prev[p];
      2'd2: return !m_s2[p] && m_prev[p];
      default: return m_s2[p] != m_prev[p];
    endcase
  endfunction

  function automatic bit exp_irq();
    bit r = 0;
    for (int p = 0; p < NP; p++)
      if (m_pend[p] && m_cfg[p][0] && m_cfg[p][7:5] == 3'd3) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [19:0] a);
    int p = int'(a[19:12]);
    if (p >= NP) return 0;
    case (a[11:0])
      12'h004: return {30'd0, m_out[p], m_s2[p]};
      12'h008: return {24'd0, m_cfg[p]};
      12'h00C: return {31'd0, m_pend[p]};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg <= '0; m_out <= '0; m_pend <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
    end else begin
      m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
      for (int p = 0; p < NP; p++) begin
        if (bus_we && int'(bus_addr[19:12]) == p) begin
          if (bus_addr[11:0] == 12'h004) m_out[p] <= bus_wdata[1];
          if (bus_addr[11:0] == 12'h008) m_cfg[p] <= bus_wdata[7:0];
        end
        if (m_cfg[p][4] && m_hit(p)) m_pend[p] <= 1'b1;
        else if (bus_we && int'(bus_addr[19:12]) == p && bus_addr[11:0] == 12'h00C && !bus_wdata[0])
          m_pend[p] <= 1'b0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [19:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [19:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    rd("R1 cfg", 20'h00008, 0); rd("R1 stat", 20'h0500C, 0);
    chk("R1 pin_out", pin_out, 0); chk("R1 irq", irq_out, 0);

    wr(20'h01004, 32'h2);
    chk("R2 out", pin_out, 8'h02);
    chk("R11 other pins", pin_out & 8'hFD, 0);
    pin_in[1] = 1; tick(1);
    rd("R2 in 1 edge", 20'h01004, 2);
    tick(1);
    rd("R2 in 2 edges", 20'h01004, 3);

    wr(20'h02008, 32'hFFFF_FF75);
    rd("R3 cfg", 20'h02008, 32'h75);
    pin_in[2] = 1; tick(2);
    rd("R5 early", 20'h0200C, 0);
    tick(1);
    rd("R5 R4 rising", 20'h0200C, 1); chk("R8 irq", irq_out, 1);
    wr(20'h0200C, 1); rd("R7 keep", 20'h0200C, 1);
    wr(20'h0200C, 0); rd("R7 clear", 20'h0200C, 0); chk("R7 irq", irq_out, 0);

    pin_in[4] = 1; tick(3);
    wr(20'h04008, 32'h79); tick(3);
    rd("R4 fall none", 20'h0400C, 0);
    pin_in[4] = 0; tick(3);
    rd("R4 fall", 20'h0400C, 1);
    wr(20'h0400C, 0);

    wr(20'h05008, 32'h7D);
    pin_in[5] = 1; tick(3); rd("R4 both up", 20'h0500C, 1);
    wr(20'h0500C, 0); rd("R4 both clr", 20'h0500C, 0);
    pin_in[5] = 0; tick(3); rd("R4 both down", 20'h0500C, 1);
    wr(20'h0500C, 0);

    wr(20'h06008, 32'h65);
    pin_in[6] = 1; tick(3); rd("R5 raw off", 20'h0600C, 0);

    wr(20'h03008, 32'h73);
    pin_in[3] = 1; tick(3); rd("R6 level", 20'h0300C, 1);
    wr(20'h0300C, 0); rd("R6 clear ignored", 20'h0300C, 1);
    pin_in[3] = 0; tick(3);
    wr(20'h0300C, 0); rd("R6 clear sticks", 20'h0300C, 0);

    wr(20'h07008, 32'h71); tick(1);
    rd("R4 active low", 20'h0700C, 1);
    wr(20'h07008, 32'h0); wr(20'h0700C, 0);
    rd("R4 low cleared", 20'h0700C, 0);

    pin_in[2] = 0; tick(3); pin_in[2] = 1; tick(3);
    rd("R9 pend", 20'h0200C, 1); chk("R9 irq on", irq_out, 1);
    wr(20'h02008, 32'h74);
    chk("R9 masked", irq_out, 0); rd("R9 pend kept", 20'h0200C, 1);
    rd("R9 fields kept", 20'h02008, 32'h74);
    wr(20'h02008, 32'h75); chk("R9 unmasked", irq_out, 1);
    wr(20'h02008, 32'h55); chk("R8 route", irq_out, 0);
    wr(20'h02008, 32'h75); chk("R8 route back", irq_out, 1);

    rd("R10 bad pin", 20'h08008, 0);
    wr(20'h08004, 32'hFFFF_FFFF); chk("R10 bad write", pin_out, 8'h02);
    rd("R10 bad ofs", 20'h02010, 0);
    wr(20'h02010, 32'hFFFF_FFFF); rd("R10 cfg intact", 20'h02008, 32'h75);
    wr(20'h02000, 32'h0); rd("R10 pend intact", 20'h0200C, 1);

    void'($urandom(32'h5EED));
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk); bus_we = 0;
      chk("R8 rand irq", irq_out, exp_irq());
      chk("R2 rand out", pin_out, m_out);
      begin
        logic [19:0] a = {4'd0, 4'($urandom_range(0, 9)), 8'd0, 4'($urandom_range(0, 4)) << 2};
        rd("R3 R10 rand read", a, exp_rd(a));
      end
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ NP'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        bus_addr = {4'd0, 4'($urandom_range(0, 9)), 8'd0, 4'($urandom_range(0, 4)) << 2};
        bus_wdata = $urandom;
        bus_we = 1;
      end
    end
    @(negedge clk); bus_we = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule